// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves parallel data between two ports, A and B, in both directions. Each direction has its own set of controls: a pass-through enable, a capture clock, an active-low capture gate and an active-low output enable. With these a direction can pass data straight through, keep the last value that passed, or capture the input on a rising edge of its own capture clock. A direction that is not passing data drives its stored word.

Each direction has one storage word, shared by the level-sensitive path and the edge-triggered path. The whole block runs on a system clock `clk`. The direction capture clocks are treated as ordinary inputs and sampled on that clock. A capture happens on a system edge where the capture clock is high and was low at the previous system edge. Tri-state pins are modelled as a data output plus a drive-enable output per port.

Top module: `univ_bus_xcvr`

## Requirements
- R1: The word width is the parameter `WIDTH` (default 18). The A-to-B and B-to-A directions are fully independent: activity on one never changes the other's output.
- R2: While a direction's pass-through enable is high, its output equals its input in the same cycle, with no register in the path.
- R3: While the pass-through enable is low and no qualified capture edge occurs, the output keeps its value whatever the input does.
- R4: With the pass-through enable low and the capture gate low, a rising capture-clock edge loads the input. The edge is seen at the system edge where the capture clock is 1 and was 0 at the previous system edge. The loaded value appears on the output right after that system edge.
- R5: While the capture gate is high, capture-clock edges are ignored. Lowering the gate while the capture clock is already high does not cause a capture.
- R6: The output enable is active-low. When it is 1 the port's drive-enable is 0; when it is 0 the drive-enable is 1.
- R7: The output enable has no effect on storage. A capture made while the drive is off shows on the output once the drive is turned back on.
- R8: When the pass-through enable falls, the output keeps the last value that passed through, which is the input sampled at the last system edge where the enable was high.
- R9: After reset every storage word is 0 and the capture-clock history is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| aIn | input | WIDTH | Data received on port A |
| aOut | output | WIDTH | Data for port A (B-to-A direction) |
| aDrive | output | 1 | Drive enable for port A |
| bIn | input | WIDTH | Data received on port B |
| bOut | output | WIDTH | Data for port B (A-to-B direction) |
| bDrive | output | 1 | Drive enable for port B |
| abOeN | input | 1 | A-to-B output enable, active-low |
| abPass | input | 1 | A-to-B pass-through enable |
| abCapClk | input | 1 | A-to-B capture clock |
| abCapEnN | input | 1 | A-to-B capture gate, active-low |
| baOeN | input | 1 | B-to-A output enable, active-low |
| baPass | input | 1 | B-to-A pass-through enable |
| baCapClk | input | 1 | B-to-A capture clock |
| baCapEnN | input | 1 | B-to-A capture gate, active-low |

## Verification
Closing the pass-through enable and a qualified capture edge can land in the same system cycle. The bench sets this up by changing the input, lowering the pass-through enable and raising the capture clock at one falling system edge. Before the next rising edge the output must still show the old word, which is the value that last passed through. Right after that edge it must show the new word, because the capture wins. Each direction is swept with arithmetically generated words, and the other direction's output is checked to be unchanged.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic passThru;
    logic edgeLoad;
    logic drive;
  } dirStrobe_t;
endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       passEn,
  input  logic       capClk,
  input  logic       capEnN,
  input  logic       oeN,
  output dirStrobe_t strobe
);
  logic clkPrev;
  logic riseSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= capClk;
  end

  assign riseSeen = capClk & ~clkPrev;

  always_comb begin
    strobe.passThru = passEn;
    strobe.edgeLoad = ~passEn & riseSeen & ~capEnN;
    strobe.drive    = ~oeN;
  end

  // R4: a capture edge can never repeat on consecutive system cycles
  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.edgeLoad |=> !strobe.edgeLoad);

  // R5: a gated capture clock yields no load
  a_r5_gated: assert property (@(posedge clk) disable iff (!rstN)
    capEnN |-> !strobe.edgeLoad);
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  dirStrobe_t       strobe,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut,
  output logic             drvEn
);
  logic [WIDTH-1:0] store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  store <= '0;
    else if (strobe.passThru || strobe.edgeLoad) store <= dIn;
  end

  always_comb begin
    dOut  = strobe.passThru ? dIn : store;
    drvEn = strobe.drive;
  end

  // R3: no load strobe keeps storage unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.passThru && !strobe.edgeLoad) |=> $stable(store));

  // R4: an edge load stores the sampled input
  a_r4_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.edgeLoad |=> store == $past(dIn));

  // R8: on closing the pass-through path, the last passed word is shown
  a_r8_close: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.passThru) |-> dOut == $past(dIn));
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  input  logic             abOeN,
  input  logic             abPass,
  input  logic             abCapClk,
  input  logic             abCapEnN,
  input  logic             baOeN,
  input  logic             baPass,
  input  logic             baCapClk,
  input  logic             baCapEnN
);
  dirStrobe_t abStrobe;
  dirStrobe_t baStrobe;

  xcvr_dir_ctrl abCtrl_i (
    .clk(clk), .rstN(rstN), .passEn(abPass), .capClk(abCapClk),
    .capEnN(abCapEnN), .oeN(abOeN), .strobe(abStrobe));

  xcvr_dir_path #(.WIDTH(WIDTH)) abPath_i (
    .clk(clk), .rstN(rstN), .strobe(abStrobe), .dIn(aIn),
    .dOut(bOut), .drvEn(bDrive));

  xcvr_dir_ctrl baCtrl_i (
    .clk(clk), .rstN(rstN), .passEn(baPass), .capClk(baCapClk),
    .capEnN(baCapEnN), .oeN(baOeN), .strobe(baStrobe));

  xcvr_dir_path #(.WIDTH(WIDTH)) baPath_i (
    .clk(clk), .rstN(rstN), .strobe(baStrobe), .dIn(bIn),
    .dOut(aOut), .drvEn(aDrive));

  // R2: pass-through follows the input
  a_r2_ab_follow: assert property (@(posedge clk) disable iff (!rstN)
    abPass |-> bOut == aIn);
  a_r2_ba_follow: assert property (@(posedge clk) disable iff (!rstN)
    baPass |-> aOut == bIn);

  // R6: active-low output enable
  a_r6_ab_drive: assert property (@(posedge clk) disable iff (!rstN)
    abOeN |-> !bDrive);
  a_r6_ba_drive: assert property (@(posedge clk) disable iff (!rstN)
    baOeN |-> !aDrive);

  // R5: gated and closed direction keeps its output
  a_r5_ab_keep: assert property (@(posedge clk) disable iff (!rstN)
    (!abPass && abCapEnN) ##1 !abPass |-> bOut == $past(bOut));
endmodule

// File: tb/univ_bus_xcvr_tb_top.sv
module univ_bus_xcvr_tb_top;
  localparam int W      = 18;
  localparam int PERIOD = 10;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0, aOut, bOut;
  logic aDrive, bDrive;
  logic abOeN = 1'b1, abPass = 1'b0, abCapClk = 1'b0, abCapEnN = 1'b1;
  logic baOeN = 1'b1, baPass = 1'b0, baCapClk = 1'b0, baCapEnN = 1'b1;
  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  univ_bus_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aDrive(aDrive),
    .bIn(bIn), .bOut(bOut), .bDrive(bDrive),
    .abOeN(abOeN), .abPass(abPass), .abCapClk(abCapClk), .abCapEnN(abCapEnN),
    .baOeN(baOeN), .baPass(baPass), .baCapClk(baCapClk), .baCapEnN(baCapEnN));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // direction 0: A-to-B, direction 1: B-to-A
  task automatic setIn(int d, logic [W-1:0] v);
    if (d == 0) aIn = v; else bIn = v;
  endtask
  task automatic setCtl(int d, logic pass, logic cclk, logic enN, logic oeN);
    if (d == 0) begin abPass = pass; abCapClk = cclk; abCapEnN = enN; abOeN = oeN; end
    else        begin baPass = pass; baCapClk = cclk; baCapEnN = enN; baOeN = oeN; end
  endtask
  function automatic logic [W-1:0] outOf(int d);
    return (d == 0) ? bOut : aOut;
  endfunction
  function automatic logic drvOf(int d);
    return (d == 0) ? bDrive : aDrive;
  endfunction

  task automatic stepOut();
    @(posedge clk); #2;
  endtask

  initial begin
    #(PERIOD*100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset B", bOut, '0);
    chk("R9 reset A", aOut, '0);
    chk("R6 reset drive B", {{(W-1){1'b0}}, bDrive}, '0);
    rstN = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 16; i++) begin
        logic [W-1:0] v, w, other;
        v = W'((i * 20011 + d * 777 + 3)) & MASK;
        w = ~v & MASK;
        other = outOf(1 - d);
        // R2 transparent follow
        @(negedge clk); setCtl(d, 1, 0, 0, 0); setIn(d, v); #2;
        chk("R2 follow", outOf(d), v);
        // R8 close keeps last passed word
        @(negedge clk); setCtl(d, 0, 0, 0, 0); setIn(d, w); #2;
        chk("R8 close", outOf(d), v);
        // R3 hold with static capture clock
        stepOut();
        chk("R3 hold", outOf(d), v);
        // R4 capture on rising edge
        @(negedge clk); setCtl(d, 0, 1, 0, 0); stepOut();
        chk("R4 capture", outOf(d), w);
        @(negedge clk); setCtl(d, 0, 0, 0, 0);
        // R5 gated edge ignored
        @(negedge clk); setIn(d, v); setCtl(d, 0, 1, 1, 0); stepOut();
        chk("R5 gated edge", outOf(d), w);
        // R5 ungating with clock already high: no capture
        @(negedge clk); setCtl(d, 0, 1, 0, 0); stepOut();
        chk("R5 late ungate", outOf(d), w);
        @(negedge clk); setCtl(d, 0, 0, 0, 0);
        // R6/R7 capture while drive off
        @(negedge clk); setCtl(d, 0, 1, 0, 1); stepOut();
        chk("R6 drive off", {{(W-1){1'b0}}, drvOf(d)}, '0);
        @(negedge clk); setCtl(d, 0, 0, 0, 0); #2;
        chk("R6 drive on", {{(W-1){1'b0}}, drvOf(d)}, {{(W-1){1'b0}}, 1'b1});
        chk("R7 stored under drive off", outOf(d), v);
        // concurrency: close and capture in the same cycle
        @(negedge clk); setCtl(d, 1, 0, 0, 0); setIn(d, v);
        @(negedge clk); setIn(d, w); setCtl(d, 0, 1, 0, 0); #2;
        chk("R8 close before edge", outOf(d), v);
        stepOut();
        chk("R4 edge wins", outOf(d), w);
        @(negedge clk); setCtl(d, 0, 0, 1, 0);
        // R1 other direction undisturbed
        #2;
        chk("R1 independence", outOf(1 - d), other);
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule